// File: doc/BRIEF.md
# Write-Back Ordering Stall Unit

This block sits in the issue stage of an in-order pipeline. Its job is to stop a younger instruction from finishing a register write before an older one. It keeps one countdown of the cycles left until the last pending write-back of the most recently issued in-order instruction commits. Each issue candidate brings up to four destination writes. For each write it gives a remaining latency and, when that latency is marked unknown, a nominal latency. The block reduces these to the candidate's earliest and latest write-back. If the earliest one would land before the countdown expires, the candidate is held back by exactly that gap.

An instruction marked as allowed to retire out of order skips the ordering check, and it does not move the countdown when it issues. A stall count coming from an external resource or group hazard takes precedence: the ordering check is not evaluated for that candidate. Two candidates per cycle are supported. The younger slot is compared against the older slot's latest write-back whenever the older slot issues in the same cycle.

Top module: `wb_order_stall`

## Requirements
- R1: After reset the countdown is zero, so a valid candidate with no external hazard reports a stall of 0 and is permitted to issue.
- R2: At each clock edge with no in-order issue, the countdown drops by one if it is nonzero and stays at zero otherwise.
- R3: When an in-order instruction (retire-anywhere flag 0) issues, the countdown is loaded with the largest effective latency among that instruction's valid writes.
- R4: A write's effective latency is its nominal latency (unsigned, 6 bits) when its unknown flag is 1. Otherwise it is its remaining latency, read as 6-bit two's complement with negative values taken as 0.
- R5: For an in-order candidate whose smallest effective latency E is below the reference count C, the stall is C − E; when E ≥ C the stall is 0.
- R6: When a candidate's external hazard count is nonzero, its stall equals that count and the ordering check is not applied.
- R7: A candidate with the retire-anywhere flag set reports no ordering stall, and issuing it leaves the countdown unchanged.
- R8: The issue-permitted output is 1 only when the candidate is valid and its stall is 0. An invalid candidate reports stall 0.
- R9: A candidate with no valid writes has an earliest write-back of all ones, so it never takes an ordering stall. Issuing it loads the countdown with 0.
- R10: When an issue load and the per-cycle decrement fall on the same edge, the loaded value wins.
- R11: Slot 1 uses slot 0's latest write-back as its reference when slot 0 issues in order in the same cycle, and the countdown otherwise. Slot 1 is permitted only if slot 0 issues. If both issue in order, the countdown takes slot 1's latest write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cand_vld_i | input | NSLOT | Candidate present, one bit per slot |
| wr_vld_i | input | NSLOT*NWR | Destination write valid; write w of slot s at bit s*NWR+w |
| wr_unk_i | input | NSLOT*NWR | Remaining latency unknown, use nominal |
| wr_rem_i | input | NSLOT*NWR*LW | Remaining latency, two's complement, field (s*NWR+w)*LW |
| wr_nom_i | input | NSLOT*NWR*LW | Nominal latency, unsigned, same field layout |
| ooo_i | input | NSLOT | Retire-anywhere flag per slot |
| hz_stall_i | input | NSLOT*LW | External hazard stall count per slot |
| issue_i | input | NSLOT | Slot actually issues this cycle |
| stall_o | output | NSLOT*LW | Final stall count per slot |
| issue_ok_o | output | NSLOT | Slot may issue this cycle |

## Verification
A table of single-candidate patterns first loads a known countdown and then shows one candidate. These patterns separate a gap stall from an exact-equal or later write-back. They also separate masked writes from valid ones, a clamped negative latency from a nominal substitution, and an exempt candidate from one stopped by an external hazard. A probe candidate whose only write has latency 0 reports the countdown directly. Directed sequences use it to show the saturating countdown, the load-over-decrement priority and the exempt instruction that leaves the count alone. Paired-slot patterns show when the younger slot compares against the older slot rather than the register, and which slot's latency ends up in the countdown.

// File: rtl/wbo_pkg.sv
package wbo_pkg;
  localparam int WBO_LAT_W  = 6;
  localparam int WBO_WRITES = 4;
  localparam int WBO_SLOTS  = 2;

  typedef enum logic [1:0] {
    STALL_NONE   = 2'd0,
    STALL_HAZARD = 2'd1,
    STALL_ORDER  = 2'd2
  } stall_src_e;
endpackage

// File: rtl/wbo_lat_reduce.sv
module wbo_lat_reduce #(
  parameter int LW  = 6,
  parameter int NWR = 4
) (
  input  logic [NWR-1:0]    wr_vld_i,
  input  logic [NWR-1:0]    wr_unk_i,
  input  logic [NWR*LW-1:0] wr_rem_i,
  input  logic [NWR*LW-1:0] wr_nom_i,
  output logic [LW-1:0]     first_o,
  output logic [LW-1:0]     last_o
);
  logic [LW-1:0] eff [NWR];

  for (genvar w = 0; w < NWR; w++) begin : g_eff
    logic [LW-1:0] rem_w, nom_w;
    assign rem_w = wr_rem_i[w*LW +: LW];
    assign nom_w = wr_nom_i[w*LW +: LW];
    always_comb begin
      if (wr_unk_i[w])         eff[w] = nom_w;
      else if (rem_w[LW-1])    eff[w] = '0;
      else                     eff[w] = rem_w;
    end
  end

  always_comb begin
    first_o = '1;
    last_o  = '0;
    for (int w = 0; w < NWR; w++) begin
      if (wr_vld_i[w]) begin
        if (eff[w] < first_o) first_o = eff[w];
        if (eff[w] > last_o)  last_o  = eff[w];
      end
    end
  end
endmodule

// File: rtl/wbo_slot_stall.sv
module wbo_slot_stall
  import wbo_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          cand_vld_i,
  input  logic          ooo_i,
  input  logic [LW-1:0] hz_stall_i,
  input  logic [LW-1:0] first_i,
  input  logic [LW-1:0] ordref_i,
  output logic [LW-1:0] stall_o
);
  stall_src_e src;
  logic       order_hit;

  assign order_hit = !ooo_i && (ordref_i != '0) && (first_i < ordref_i);

  always_comb begin
    if (!cand_vld_i)            src = STALL_NONE;
    else if (hz_stall_i != '0)  src = STALL_HAZARD;
    else if (order_hit)         src = STALL_ORDER;
    else                        src = STALL_NONE;
  end

  always_comb begin
    unique case (src)
      STALL_HAZARD: stall_o = hz_stall_i;
      STALL_ORDER:  stall_o = ordref_i - first_i;
      default:      stall_o = '0;
    endcase
  end
endmodule

// File: rtl/wbo_countdown.sv
module wbo_countdown #(
  parameter int LW    = 6,
  parameter int NSLOT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NSLOT-1:0]    load_en_i,
  input  logic [NSLOT*LW-1:0] load_val_i,
  output logic [LW-1:0]       cnt_o
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (load_en_i[s]) cnt_d = load_val_i[s*LW +: LW];
    end
  end

  assign cnt_en = (|load_en_i) || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wb_order_stall.sv
module wb_order_stall
  import wbo_pkg::*;
#(
  parameter int LW    = WBO_LAT_W,
  parameter int NWR   = WBO_WRITES,
  parameter int NSLOT = WBO_SLOTS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSLOT-1:0]        cand_vld_i,
  input  logic [NSLOT*NWR-1:0]    wr_vld_i,
  input  logic [NSLOT*NWR-1:0]    wr_unk_i,
  input  logic [NSLOT*NWR*LW-1:0] wr_rem_i,
  input  logic [NSLOT*NWR*LW-1:0] wr_nom_i,
  input  logic [NSLOT-1:0]        ooo_i,
  input  logic [NSLOT*LW-1:0]     hz_stall_i,
  input  logic [NSLOT-1:0]        issue_i,
  output logic [NSLOT*LW-1:0]     stall_o,
  output logic [NSLOT-1:0]        issue_ok_o
);
  localparam int SLW = NWR * LW;

  logic [1:0]          rst_q;
  logic                rst_n_sync;
  logic [LW-1:0]       cd_q;
  logic [LW-1:0]       ordref [NSLOT+1];
  logic [NSLOT*LW-1:0] last_all;
  logic [NSLOT-1:0]    load_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_sync = rst_q[1];

  assign ordref[0] = cd_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [LW-1:0] first_s, last_s, stall_s;
    logic          older_ok;

    wbo_lat_reduce #(.LW(LW), .NWR(NWR)) i_reduce (
      .wr_vld_i (wr_vld_i[s*NWR +: NWR]),
      .wr_unk_i (wr_unk_i[s*NWR +: NWR]),
      .wr_rem_i (wr_rem_i[s*SLW +: SLW]),
      .wr_nom_i (wr_nom_i[s*SLW +: SLW]),
      .first_o  (first_s),
      .last_o   (last_s)
    );

    wbo_slot_stall #(.LW(LW)) i_stall (
      .cand_vld_i (cand_vld_i[s]),
      .ooo_i      (ooo_i[s]),
      .hz_stall_i (hz_stall_i[s*LW +: LW]),
      .first_i    (first_s),
      .ordref_i   (ordref[s]),
      .stall_o    (stall_s)
    );

    if (s == 0) begin : g_head
      assign older_ok = 1'b1;
    end else begin : g_tail
      assign older_ok = issue_i[s-1];
    end

    assign load_en[s]             = issue_i[s] && cand_vld_i[s] && !ooo_i[s];
    assign ordref[s+1]            = load_en[s] ? last_s : ordref[s];
    assign last_all[s*LW +: LW]   = last_s;
    assign stall_o[s*LW +: LW]    = stall_s;
    assign issue_ok_o[s]          = cand_vld_i[s] && (stall_s == '0) && older_ok;
  end

  wbo_countdown #(.LW(LW), .NSLOT(NSLOT)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .load_en_i  (load_en),
    .load_val_i (last_all),
    .cnt_o      (cd_q)
  );
endmodule

// File: rtl/wb_order_stall_chk.sv
module wb_order_stall_chk #(
  parameter int LW    = 6,
  parameter int NSLOT = 2
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic [LW-1:0]       cd,
  input logic [NSLOT-1:0]    cand_vld,
  input logic [NSLOT-1:0]    ooo,
  input logic [NSLOT-1:0]    issue,
  input logic [NSLOT*LW-1:0] hz,
  input logic [NSLOT*LW-1:0] stall,
  input logic [NSLOT-1:0]    ok
);
  logic any_load;
  assign any_load = |(issue & cand_vld & ~ooo);

  a_r2_decrement: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cd != '0 && !any_load) |=> cd == $past(cd) - 1'b1);

  a_r2_floor: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cd == '0 && !any_load) |=> cd == '0);

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    a_r8_ok_needs_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
      ok[s] |-> (cand_vld[s] && stall[s*LW +: LW] == '0));

    a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
      !cand_vld[s] |-> (stall[s*LW +: LW] == '0 && !ok[s]));

    a_r6_hazard_count: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cand_vld[s] && hz[s*LW +: LW] != '0) |-> stall[s*LW +: LW] == hz[s*LW +: LW]);

    a_r7_exempt_free: assert property (@(posedge clk_i) disable iff (!rst_n)
      (cand_vld[s] && ooo[s] && hz[s*LW +: LW] == '0) |-> stall[s*LW +: LW] == '0);

    if (s > 0) begin : g_young
      a_r11_older_first: assert property (@(posedge clk_i) disable iff (!rst_n)
        ok[s] |-> issue[s-1]);
    end
  end
endmodule

bind wb_order_stall wb_order_stall_chk #(.LW(LW), .NSLOT(NSLOT)) i_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_n_sync),
  .cd       (cd_q),
  .cand_vld (cand_vld_i),
  .ooo      (ooo_i),
  .issue    (issue_i),
  .hz       (hz_stall_i),
  .stall    (stall_o),
  .ok       (issue_ok_o)
);

// File: tb/test_wb_order_stall.sv
module test_wb_order_stall;
  localparam int LW = 6, NWR = 4, NSLOT = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NSLOT-1:0]        cand_vld;
  logic [NSLOT*NWR-1:0]    wr_vld, wr_unk;
  logic [NSLOT*NWR*LW-1:0] wr_rem, wr_nom;
  logic [NSLOT-1:0]        ooo, issue;
  logic [NSLOT*LW-1:0]     hz, stall;
  logic [NSLOT-1:0]        ok;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  wb_order_stall i_wb_order_stall (
    .clk_i(clk), .rst_ni(rst_n), .cand_vld_i(cand_vld), .wr_vld_i(wr_vld),
    .wr_unk_i(wr_unk), .wr_rem_i(wr_rem), .wr_nom_i(wr_nom), .ooo_i(ooo),
    .hz_stall_i(hz), .issue_i(issue), .stall_o(stall), .issue_ok_o(ok)
  );

  typedef struct packed {
    logic [5:0]  pre;
    logic [3:0]  vld;
    logic [3:0]  unk;
    logic [23:0] rem;
    logic [5:0]  nom;
    logic        oo;
    logic [5:0]  hzc;
    logic [5:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{6'd5, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd2},  6'd0, 1'b0, 6'd0, 6'd3, 4'd5}, // R5 gap
    '{6'd5, 4'b0011, 4'b0000, {6'd0, 6'd0, 6'd4, 6'd7},  6'd0, 1'b0, 6'd0, 6'd1, 4'd5}, // R5 min of two
    '{6'd5, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd6},  6'd0, 1'b0, 6'd0, 6'd0, 4'd5}, // R5 later
    '{6'd5, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd5},  6'd0, 1'b0, 6'd0, 6'd0, 4'd5}, // R5 equal
    '{6'd4, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'h3D}, 6'd0, 1'b0, 6'd0, 6'd4, 4'd4}, // R4 negative
    '{6'd6, 4'b0001, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd0},  6'd2, 1'b0, 6'd0, 6'd4, 4'd4}, // R4 nominal
    '{6'd6, 4'b0000, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd0},  6'd0, 1'b0, 6'd0, 6'd0, 4'd9}, // R9 no writes
    '{6'd6, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd0},  6'd0, 1'b1, 6'd0, 6'd0, 4'd7}, // R7 exempt
    '{6'd6, 4'b0001, 4'b0000, {6'd0, 6'd0, 6'd0, 6'd0},  6'd0, 1'b0, 6'd2, 6'd2, 4'd6}, // R6 hazard
    '{6'd3, 4'b1001, 4'b0000, {6'd1, 6'd0, 6'd0, 6'd9},  6'd0, 1'b0, 6'd0, 6'd2, 4'd5}, // R5 sparse mask
    '{6'd3, 4'b0010, 4'b0000, {6'd0, 6'd0, 6'd3, 6'd0},  6'd0, 1'b0, 6'd0, 6'd0, 4'd9}  // R9 masked zero
  };

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    cand_vld = '0; wr_vld = '0; wr_unk = '0; wr_rem = '0; wr_nom = '0;
    ooo = '0; hz = '0; issue = '0;
  endtask

  task automatic set_slot(input int s, input logic [3:0] v, input logic [3:0] u,
                          input logic [23:0] rem, input logic [5:0] nom,
                          input logic o, input logic [5:0] h, input logic iss);
    cand_vld[s] = 1'b1;
    wr_vld[s*NWR +: NWR] = v;
    wr_unk[s*NWR +: NWR] = u;
    wr_rem[s*NWR*LW +: NWR*LW] = rem;
    wr_nom[s*NWR*LW +: NWR*LW] = {4{nom}};
    ooo[s] = o;
    hz[s*LW +: LW] = h;
    issue[s] = iss;
  endtask

  // issue one in-order instruction whose single write has latency p
  task automatic preload(input logic [5:0] p);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, p}, 6'd0, 1'b0, 6'd0, 1'b1);
  endtask

  // a zero-latency probe reports the countdown as its stall
  task automatic probe(input string tag, input int exp);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, 24'd0, 6'd0, 1'b0, 6'd0, 1'b0);
    #5 check(tag, int'(stall[LW-1:0]), exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    probe("R1 stall after reset", 0);
    check("R1 ok after reset", int'(ok[0]), 1);
    // R8: invalid candidate with hazard input
    @(negedge clk);
    clear_in();
    hz[LW-1:0] = 6'd3;
    #5 check("R8 idle stall", int'(stall[LW-1:0]), 0);
    check("R8 idle ok", int'(ok[0]), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      preload(TBL[i].pre);
      @(negedge clk);
      clear_in();
      set_slot(0, TBL[i].vld, TBL[i].unk, TBL[i].rem, TBL[i].nom, TBL[i].oo, TBL[i].hzc, 1'b0);
      #5 check($sformatf("R%0d vector %0d stall", TBL[i].req, i), int'(stall[LW-1:0]), int'(TBL[i].exp));
      check($sformatf("R8 vector %0d ok", i), int'(ok[0]), (TBL[i].exp == 0) ? 1 : 0);
    end

    // R2: countdown falls to zero and stays
    preload(6'd3);
    for (int k = 0; k < 5; k++) probe($sformatf("R2 step %0d", k), (3 - k > 0) ? 3 - k : 0);

    // R3 with R4: load takes max effective latency, unknown write uses nominal
    preload(6'd0);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0111, 4'b0100, {6'd0, 6'd0, 6'd9, 6'd2}, 6'd12, 1'b0, 6'd0, 1'b1);
    probe("R3 max load", 12);

    // R9: issuing an instruction without writes loads zero
    preload(6'd5);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0000, 4'b0000, 24'd0, 6'd0, 1'b0, 6'd0, 1'b1);
    probe("R9 empty load", 0);

    // R10: load beats decrement; R7: exempt issue leaves count
    preload(6'd5);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd7}, 6'd0, 1'b0, 6'd0, 1'b1);
    #5 check("R10 issuing stall", int'(stall[LW-1:0]), 0);
    probe("R10 loaded value", 7);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd1}, 6'd0, 1'b1, 6'd0, 1'b1);
    #5 check("R7 exempt stall", int'(stall[LW-1:0]), 0);
    probe("R7 count kept", 5);

    // R11: younger slot against older slot
    preload(6'd0);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd6}, 6'd0, 1'b0, 6'd0, 1'b1);
    set_slot(1, 4'b0001, 4'b0000, {18'd0, 6'd2}, 6'd0, 1'b0, 6'd0, 1'b0);
    #5 check("R11 pair stall", int'(stall[2*LW-1:LW]), 4);
    check("R11 pair ok", int'(ok[1]), 0);

    preload(6'd0);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd6}, 6'd0, 1'b0, 6'd0, 1'b0);
    set_slot(1, 4'b0001, 4'b0000, {18'd0, 6'd2}, 6'd0, 1'b0, 6'd0, 1'b0);
    #5 check("R11 older held stall", int'(stall[2*LW-1:LW]), 0);
    check("R11 older held ok", int'(ok[1]), 0);

    preload(6'd0);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd6}, 6'd0, 1'b0, 6'd0, 1'b1);
    set_slot(1, 4'b0001, 4'b0000, {18'd0, 6'd8}, 6'd0, 1'b0, 6'd0, 1'b1);
    #5 check("R11 both ok", int'(ok[1]), 1);
    probe("R11 younger loads", 8);

    preload(6'd0);
    @(negedge clk);
    clear_in();
    set_slot(0, 4'b0001, 4'b0000, {18'd0, 6'd6}, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(1, 4'b0001, 4'b0000, {18'd0, 6'd2}, 6'd0, 1'b0, 6'd0, 1'b0);
    #5 check("R11 exempt older stall", int'(stall[2*LW-1:LW]), 0);
    check("R11 exempt older ok", int'(ok[1]), 1);

    @(negedge clk);
    clear_in();
    finish_run();
  end
endmodule